// File: doc/BRIEF.md
# Multi-cycle FP pipeline stall unit

This block decides, cycle by cycle, whether the instruction sitting in the decode stage of an in-order five-stage pipeline may move on into execution. The pipeline has three execution pipes. The integer pipe takes one cycle and also carries loads, stores and branches. The FP add pipe takes three cycles and the FP multiply pipe takes eight. Both FP pipes accept a new operation every cycle. Because the pipes differ in length, results can complete out of order. The unit therefore guards against read-after-write, write-after-write and writeback-port conflicts.

The unit keeps its own picture of what is in flight. Each pipe is a shift register of tags, and each tag holds a valid bit, a write flag, a load flag and a destination register. These tags feed a shared memory-stage tag and a shared writeback-stage tag. When the decode instruction issues, its tag enters the first stage of its pipe. When the stall output is high, a bubble enters instead, and the fetch and decode stages of the host pipeline hold their contents. Full bypassing is assumed, so the unit also reports, for each source operand of an issuing instruction, whether that operand is taken from a bypass rather than from the register file. Register indices form one space: integer registers are 0 to 31 and FP registers are 32 to 63.

Top module: `hz_stall_unit`

## Requirements
- R1: After a synchronous active-low reset, nothing is tracked. No stall and no bypass flag is raised for any decode content until new instructions issue.
- R2: A result from the integer class (code 0) is bypassed to an ALU consumer in the very next cycle with no stall, and fwd_rs is high in that issuing cycle.
- R3: A consumer that reads the destination of a load (class code 1) stalls for exactly one cycle when it directly follows the load.
- R4: A consumer of an FP add (code 4) or FP multiply (code 5) result stalls until the producer is in its last execute stage. Back to back, that is 2 stall cycles for an add and 7 for a multiply.
- R5: A branch (class code 3) needs its operands in decode, so it waits one cycle longer than an ALU consumer. Directly behind an integer producer it stalls 1 cycle, and directly behind a load it stalls 2.
- R6: An instruction that writes register d stalls while any in-flight writer of d has more cycles left before reaching the memory stage than the new instruction's execute latency. The older instruction is never cancelled.
- R7: An instruction with execute latency L stalls when any in-flight instruction is exactly L+1 cycles away from entering the memory stage, so that at most one instruction enters the memory stage per cycle.
- R8: Writes to register 0 are never tracked and never cause a stall or a bypass.
- R9: Stall is low whenever id_valid is low. A stalled instruction is not recorded, so it creates no hazard for later instructions.
- R10: fwd_rs or fwd_rt is high only in a cycle in which the instruction issues and the corresponding source matches an in-flight writer that is in the execute, memory or writeback stage.
- R11: A source whose use flag is low takes no part in hazard checks or bypass flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_class | input | 3 | Class: 0 int, 1 load, 2 store, 3 branch, 4 FP add, 5 FP multiply |
| id_rs | input | 6 | First source register |
| id_rs_use | input | 1 | First source is read |
| id_rt | input | 6 | Second source register |
| id_rt_use | input | 1 | Second source is read |
| id_rd | input | 6 | Destination register |
| id_rd_wr | input | 1 | Instruction writes id_rd |
| stall | output | 1 | Hold fetch and decode, send a bubble to execute |
| stall_raw | output | 1 | Stall cause: operand not ready |
| stall_waw | output | 1 | Stall cause: write order |
| stall_struct | output | 1 | Stall cause: memory/writeback slot conflict |
| fwd_rs | output | 1 | First source is taken from a bypass on issue |
| fwd_rt | output | 1 | Second source is taken from a bypass on issue |

## Verification
The assertions assume that the host pipeline obeys the stall: a stalled instruction is either held or withdrawn, and is never counted as issued. They also assume that id_class carries only the six defined codes. The bench applies each instruction only through id_valid and treats a cycle as an issue only when stall reads low. Every trial is drained with idle cycles before the next one starts, so each expected stall count depends only on the producer and consumer pair under test.

// File: rtl/hz_pkg.sv
// Shared definitions for the stall unit: register index width, class codes,
// pipe numbering and the tag carried through each tracking stage.
package hz_pkg;
    parameter int REG_W = 6;

    typedef enum logic [2:0] {
        CL_INT    = 3'd0,
        CL_LOAD   = 3'd1,
        CL_STORE  = 3'd2,
        CL_BRANCH = 3'd3,
        CL_FADD   = 3'd4,
        CL_FMUL   = 3'd5
    } op_class_e;

    localparam int NUM_PIPE = 3;
    localparam int PIPE_INT = 0;
    localparam int PIPE_ADD = 1;
    localparam int PIPE_MUL = 2;

    typedef struct packed {
        logic             vld;
        logic             wr;
        logic             ld;
        logic [REG_W-1:0] dst;
    } slot_t;
endpackage

// File: rtl/hz_pipe_track.sv
// Tag shift register modelling one execute pipe of DEPTH stages.
// Assumes the caller drives an all-zero tag (bubble) when nothing issues.
module hz_pipe_track
    import hz_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  slot_t in_slot,
    output slot_t stg [DEPTH]
);
    // Advance every tag one stage per cycle; reset empties the pipe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else begin
            stg[0] <= in_slot;
            for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
    end
endmodule

// File: rtl/hz_slot_check.sv
// Compares the decode instruction against one tracked stage.
// REM is the number of cycles until that stage's tag enters the memory stage:
// >=2 early execute, 1 last execute, 0 memory stage, -1 writeback stage.
// Assumes the tag's wr bit is already cleared for writes to register 0.
module hz_slot_check
    import hz_pkg::*;
#(
    parameter int REM   = 1,
    parameter int LAT_W = 4
) (
    input  slot_t             s,
    input  logic [REG_W-1:0]  rs,
    input  logic              rs_use,
    input  logic [REG_W-1:0]  rt,
    input  logic              rt_use,
    input  logic [REG_W-1:0]  rd,
    input  logic              rd_wr,
    input  logic [LAT_W-1:0]  new_lat,
    input  logic              is_br,
    output logic              hit_rs,
    output logic              hit_rt,
    output logic              raw_rs,
    output logic              raw_rt,
    output logic              waw,
    output logic              strc
);
    localparam bit EARLY  = (REM >= 2);
    localparam bit LASTEX = (REM == 1);
    localparam bit INMEM  = (REM == 0);

    logic writer;
    logic not_ready;

    // Readiness of this stage's result for a consumer in decode, plus conflicts.
    always_comb begin
        writer    = s.vld && s.wr;
        not_ready = writer && (EARLY
                               || (LASTEX && (s.ld || is_br))
                               || (INMEM && s.ld && is_br));
        hit_rs    = writer && rs_use && (rs == s.dst);
        hit_rt    = writer && rt_use && (rt == s.dst);
        raw_rs    = hit_rs && not_ready;
        raw_rt    = hit_rt && not_ready;
        waw       = writer && rd_wr && (rd != '0) && (rd == s.dst)
                    && (REM > int'(new_lat));
        strc      = s.vld && (REM == int'(new_lat) + 1);
    end
endmodule

// File: rtl/hz_stall_unit.sv
// Decode-stage hazard and stall unit for an in-order pipeline with one
// integer pipe and two pipelined FP execute pipes of different length.
// Tracks issued instructions as tags, raises stall on RAW, WAW and
// memory/writeback slot conflicts, and flags bypassed operands on issue.
// Assumes the host holds or withdraws a stalled instruction.
module hz_stall_unit
    import hz_pkg::*;
#(
    parameter int LAT_INT = 1,
    parameter int LAT_ADD = 3,
    parameter int LAT_MUL = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             id_valid,
    input  logic [2:0]       id_class,
    input  logic [REG_W-1:0] id_rs,
    input  logic             id_rs_use,
    input  logic [REG_W-1:0] id_rt,
    input  logic             id_rt_use,
    input  logic [REG_W-1:0] id_rd,
    input  logic             id_rd_wr,
    output logic             stall,
    output logic             stall_raw,
    output logic             stall_waw,
    output logic             stall_struct,
    output logic             fwd_rs,
    output logic             fwd_rt
);
    localparam int LAT_MAX = (LAT_MUL > LAT_ADD) ? LAT_MUL : LAT_ADD;
    localparam int LAT_W   = $clog2(LAT_MAX + 2);
    localparam int LATS [NUM_PIPE] = '{LAT_INT, LAT_ADD, LAT_MUL};
    localparam int NSRC    = NUM_PIPE + 2;
    localparam int IDX_MEM = NUM_PIPE;
    localparam int IDX_WB  = NUM_PIPE + 1;

    logic [NUM_PIPE-1:0] pipe_sel;
    logic [LAT_W-1:0]    new_lat;
    logic                is_br;
    logic                is_ld;
    logic                issue;
    slot_t               new_slot;
    slot_t               pipe_in   [NUM_PIPE];
    slot_t               last_slot [NUM_PIPE];
    logic [NUM_PIPE-1:0] last_vld;
    logic [NUM_PIPE-1:0] head_vld;
    slot_t               mem_d, mem_q, wb_q;
    logic [NSRC-1:0]     v_hit_rs, v_hit_rt, v_raw_rs, v_raw_rt, v_waw, v_strc;

    // Decode the class into pipe choice, execute latency and consumer kind.
    always_comb begin
        pipe_sel = '0;
        new_lat  = LAT_W'(LAT_INT);
        is_br    = (id_class == CL_BRANCH);
        is_ld    = (id_class == CL_LOAD);
        case (id_class)
            CL_FADD: begin pipe_sel[PIPE_ADD] = 1'b1; new_lat = LAT_W'(LAT_ADD); end
            CL_FMUL: begin pipe_sel[PIPE_MUL] = 1'b1; new_lat = LAT_W'(LAT_MUL); end
            default: pipe_sel[PIPE_INT] = 1'b1;
        endcase
    end

    // Build the tag for the decode instruction and route it to its pipe.
    always_comb begin
        issue        = id_valid && !stall;
        new_slot.vld = 1'b1;
        new_slot.wr  = id_rd_wr && (id_rd != '0);
        new_slot.ld  = is_ld;
        new_slot.dst = id_rd;
        for (int p = 0; p < NUM_PIPE; p++)
            pipe_in[p] = (issue && pipe_sel[p]) ? new_slot : '0;
    end

    for (genvar p = 0; p < NUM_PIPE; p++) begin : g_pipe
        slot_t stg [LATS[p]];
        logic [LATS[p]-1:0] h_rs, h_rt, r_rs, r_rt, w, st;

        hz_pipe_track #(.DEPTH(LATS[p])) u_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_slot (pipe_in[p]),
            .stg     (stg)
        );

        for (genvar i = 0; i < LATS[p]; i++) begin : g_stage
            hz_slot_check #(.REM(LATS[p] - i), .LAT_W(LAT_W)) u_chk (
                .s (stg[i]), .rs (id_rs), .rs_use (id_rs_use), .rt (id_rt),
                .rt_use (id_rt_use), .rd (id_rd), .rd_wr (id_rd_wr),
                .new_lat (new_lat), .is_br (is_br),
                .hit_rs (h_rs[i]), .hit_rt (h_rt[i]), .raw_rs (r_rs[i]),
                .raw_rt (r_rt[i]), .waw (w[i]), .strc (st[i])
            );
        end

        assign last_slot[p]  = stg[LATS[p]-1];
        assign last_vld[p]   = stg[LATS[p]-1].vld;
        assign head_vld[p]   = stg[0].vld;
        assign v_hit_rs[p]   = |h_rs;
        assign v_hit_rt[p]   = |h_rt;
        assign v_raw_rs[p]   = |r_rs;
        assign v_raw_rt[p]   = |r_rt;
        assign v_waw[p]      = |w;
        assign v_strc[p]     = |st;
    end

    // Merge the pipe outputs into the single memory-stage tag.
    always_comb begin
        mem_d = '0;
        for (int p = 0; p < NUM_PIPE; p++)
            if (last_slot[p].vld) mem_d = last_slot[p];
    end

    // Shared memory and writeback stage tags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
            wb_q  <= '0;
        end else begin
            mem_q <= mem_d;
            wb_q  <= mem_q;
        end
    end

    hz_slot_check #(.REM(0), .LAT_W(LAT_W)) u_chk_mem (
        .s (mem_q), .rs (id_rs), .rs_use (id_rs_use), .rt (id_rt),
        .rt_use (id_rt_use), .rd (id_rd), .rd_wr (id_rd_wr),
        .new_lat (new_lat), .is_br (is_br),
        .hit_rs (v_hit_rs[IDX_MEM]), .hit_rt (v_hit_rt[IDX_MEM]),
        .raw_rs (v_raw_rs[IDX_MEM]), .raw_rt (v_raw_rt[IDX_MEM]),
        .waw (v_waw[IDX_MEM]), .strc (v_strc[IDX_MEM])
    );

    hz_slot_check #(.REM(-1), .LAT_W(LAT_W)) u_chk_wb (
        .s (wb_q), .rs (id_rs), .rs_use (id_rs_use), .rt (id_rt),
        .rt_use (id_rt_use), .rd (id_rd), .rd_wr (id_rd_wr),
        .new_lat (new_lat), .is_br (is_br),
        .hit_rs (v_hit_rs[IDX_WB]), .hit_rt (v_hit_rt[IDX_WB]),
        .raw_rs (v_raw_rs[IDX_WB]), .raw_rt (v_raw_rt[IDX_WB]),
        .waw (v_waw[IDX_WB]), .strc (v_strc[IDX_WB])
    );

    // Combine per-stage findings into the stall causes and bypass flags.
    always_comb begin
        stall_raw    = id_valid && (|(v_raw_rs | v_raw_rt));
        stall_waw    = id_valid && (|v_waw);
        stall_struct = id_valid && (|v_strc);
        stall        = stall_raw || stall_waw || stall_struct;
        fwd_rs       = id_valid && !stall && (|v_hit_rs);
        fwd_rt       = id_valid && !stall && (|v_hit_rt);
    end

    // R7: the structural check keeps the memory stage to one entrant per cycle.
    assert_mem_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(last_vld));

    // R9: no decode instruction means no stall.
    assert_idle_no_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |-> !stall);

    // R9: a stall sends a bubble into every execute pipe.
    assert_bubble_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (head_vld == '0));

    // R1: leaving reset, no stall cause can be present.
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !(stall_raw || stall_waw || stall_struct));

    // R10: a bypass flag is never raised in a stalled cycle.
    assert_fwd_issue_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_rs || fwd_rt) |-> !stall);
endmodule

// File: tb/test_hz_stall_unit.sv
module test_hz_stall_unit;
    localparam int RW = hz_pkg::REG_W;

    logic clk = 1'b0;
    logic rst_n;
    logic id_valid, id_rs_use, id_rt_use, id_rd_wr;
    logic [2:0] id_class;
    logic [RW-1:0] id_rs, id_rt, id_rd;
    logic stall, stall_raw, stall_waw, stall_struct, fwd_rs, fwd_rt;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    hz_stall_unit i_hz_stall_unit (
        .clk (clk), .rst_n (rst_n), .id_valid (id_valid), .id_class (id_class),
        .id_rs (id_rs), .id_rs_use (id_rs_use), .id_rt (id_rt),
        .id_rt_use (id_rt_use), .id_rd (id_rd), .id_rd_wr (id_rd_wr),
        .stall (stall), .stall_raw (stall_raw), .stall_waw (stall_waw),
        .stall_struct (stall_struct), .fwd_rs (fwd_rs), .fwd_rt (fwd_rt)
    );

    function automatic int lat(int cls);
        if (cls == 4) return 3;
        if (cls == 5) return 8;
        return 1;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic put(bit v, int cls, int rs, bit rsu, int rt, bit rtu, int rd, bit wr);
        id_valid  = v;
        id_class  = 3'(cls);
        id_rs     = RW'(rs);
        id_rs_use = rsu;
        id_rt     = RW'(rt);
        id_rt_use = rtu;
        id_rd     = RW'(rd);
        id_rd_wr  = wr;
    endtask

    task automatic idle(int n);
        id_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Hold the current decode content until it issues; return stall cycles.
    task automatic hold(output int stalls, output int fw);
        stalls = 0;
        forever begin
            #1;
            if (!stall || stalls > 30) break;
            stalls++;
            @(negedge clk);
        end
        fw = fwd_rs;
        @(negedge clk);
    endtask

    // Producer then consumer after d idle cycles; expected counts from the rules.
    task automatic trial(int pc, int cc, int d, bit dep);
        int lp, lc, need, c, exp_st, st, fw;
        string tag;
        lp = lat(pc);
        lc = lat(cc);
        put(1, pc, 1, 0, 2, 0, 40, 1);
        #1;
        chk("R2 producer issues into empty pipes", stall, 0);
        @(negedge clk);
        idle(d);
        put(1, cc, 40, dep, 3, 0, (cc == 3) ? 0 : 60, cc != 3);
        hold(st, fw);
        idle(12);
        need = lp + ((pc == 1) ? 1 : 0) + ((cc == 3) ? 1 : 0);
        exp_st = 0;
        c = 1 + d;
        while ((dep && c < need) || (lp > lc && c == lp - lc)) begin
            exp_st++;
            c++;
        end
        if (!dep)            tag = "R7 structural stall count";
        else if (cc == 3)    tag = "R5 branch stall count";
        else if (pc == 1)    tag = "R3 load-use stall count";
        else if (pc >= 4)    tag = "R4 FP producer stall count";
        else                 tag = "R2 integer forward stall count";
        chk(tag, st, exp_st);
        if (dep) chk("R10 bypass flag on issue", fw, (c <= lp + 2) ? 1 : 0);
        else     chk("R11 unused source gives no bypass", fw, 0);
    endtask

    initial begin
        int st, fw;
        int pcs [4] = '{0, 1, 4, 5};
        int ccs [3] = '{0, 3, 4};
        put(0, 0, 0, 0, 0, 0, 0, 0);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state with a busy-looking decode instruction
        put(1, 5, 5, 1, 6, 1, 7, 1);
        #1;
        chk("R1 no stall after reset", stall, 0);
        chk("R1 no bypass after reset", fwd_rs | fwd_rt, 0);
        idle(1);
        idle(12);

        // R1: reset while a multiply is in flight clears it
        put(1, 5, 1, 0, 2, 0, 40, 1);
        @(negedge clk);
        id_valid = 0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        put(1, 0, 40, 1, 2, 0, 50, 1);
        #1;
        chk("R1 reset drops in-flight writer", stall, 0);
        chk("R1 reset drops in-flight bypass", fwd_rs, 0);
        @(negedge clk);
        idle(12);

        // R6: WAW, multiply then add to same register
        put(1, 5, 1, 0, 2, 0, 40, 1);
        @(negedge clk);
        put(1, 4, 0, 0, 0, 0, 40, 1);
        #1;
        chk("R6 waw cause raised", stall_waw, 1);
        @(negedge clk);
        put(1, 4, 0, 0, 0, 0, 40, 1);
        hold(st, fw);
        chk("R6 waw add behind multiply", st + 1, 5);
        idle(12);

        // R6: same pair with distinct destinations does not stall
        put(1, 5, 1, 0, 2, 0, 40, 1);
        @(negedge clk);
        put(1, 4, 0, 0, 0, 0, 41, 1);
        hold(st, fw);
        chk("R6 distinct destinations no stall", st, 0);
        idle(12);

        // R6: load behind add to same register
        put(1, 4, 1, 0, 2, 0, 42, 1);
        @(negedge clk);
        put(1, 1, 0, 0, 0, 0, 42, 1);
        hold(st, fw);
        chk("R6 waw load behind add", st, 2);
        idle(12);

        // R8: register 0 writes are not tracked
        put(1, 0, 1, 0, 2, 0, 0, 1);
        @(negedge clk);
        put(1, 3, 0, 1, 0, 1, 0, 0);
        #1;
        chk("R8 zero register no stall", stall, 0);
        chk("R8 zero register no bypass", fwd_rs | fwd_rt, 0);
        @(negedge clk);
        idle(12);

        // R11: unused source not checked
        put(1, 0, 1, 0, 2, 0, 40, 1);
        @(negedge clk);
        put(1, 3, 40, 0, 40, 0, 0, 0);
        #1;
        chk("R11 unused sources no stall", stall, 0);
        @(negedge clk);
        idle(12);

        // R10: second source bypass flag
        put(1, 0, 1, 0, 2, 0, 45, 1);
        @(negedge clk);
        put(1, 0, 3, 1, 45, 1, 46, 1);
        #1;
        chk("R10 fwd_rt on matching second source", fwd_rt, 1);
        chk("R10 fwd_rs clear on non-matching source", fwd_rs, 0);
        @(negedge clk);
        idle(12);

        // R9: idle decode hides a hazard; withdrawn stalled writer not tracked
        put(1, 5, 1, 0, 2, 0, 40, 1);
        @(negedge clk);
        put(0, 0, 40, 1, 0, 0, 50, 1);
        #1;
        chk("R9 no stall while decode is empty", stall, 0);
        @(negedge clk);
        put(1, 0, 40, 1, 0, 0, 50, 1);
        #1;
        chk("R9 hazard stalls once valid", stall, 1);
        @(negedge clk);
        put(1, 4, 50, 1, 0, 0, 51, 1);
        #1;
        chk("R9 stalled writer left no trace", stall, 0);
        chk("R9 stalled writer gives no bypass", fwd_rs, 0);
        @(negedge clk);
        idle(14);

        // Sweep: producer class x consumer class x gap x dependence
        foreach (pcs[a])
            foreach (ccs[b])
                for (int d = 0; d < 10; d++)
                    for (int dep = 0; dep < 2; dep++)
                        trial(pcs[a], ccs[b], d, dep[0]);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule